// File: doc/BRIEF.md
# Instruction Packet Front End

This block feeds a decode stage one instruction per cycle, taken from atomic instruction packets. A packet is a run of 32-bit words, and the last word carries an end-of-packet flag. Packets come from one of two stores. The first is a small fully associative packet cache that is filled from memory. The second is a short first-in first-out instruction buffer that accepts words written straight in, for example code sent over by another core or code meant to be read only once.

Software controls execution with fetch commands and a next-packet command. A fetch names the start address of a packet and can mark it as repeating. A fetch never redirects the packet that is running. It waits in a one-entry pending slot until the current packet retires its last word. A cache miss sends one request to memory, and the words that return are placed in cache slots in arrival order. The instruction buffer always wins over a ready cache packet. A repeating packet runs again and again until a next-packet command or a newer fetch ends it. Between two packets the selector spends one idle cycle deciding what to run next.

The control runs through two enumerated state machines.

The run machine has three states:
- RS_IDLE picks the next packet. Its transitions are: buffer not empty goes to RS_BUF; pending packet ready goes to RS_CACHE; repeat of a persistent packet goes to RS_CACHE; otherwise it stays in RS_IDLE.
- RS_BUF and RS_CACHE each return to RS_IDLE when an end-of-packet word is accepted downstream.

The fill machine also has three states:
- FS_IDLE moves to FS_REQ when a fetch misses.
- FS_REQ always moves to FS_WAIT after one cycle, in which the memory request is issued.
- FS_WAIT moves to FS_IDLE when the end-of-packet word arrives.

Top module: `pkt_front_end`

## Requirements
- R1: After reset, instr_valid, mem_req_valid and fetch_stall are all low.
- R2: While stall_in is high, a valid instruction on instr_data stays valid and unchanged. No word is consumed until stall_in falls.
- R3: Bit 31 of a word is the end-of-packet flag. A fetch whose address matches no valid tag raises mem_req_valid for exactly one cycle, with that address on mem_req_addr. The returned words are issued once the flagged word has arrived. A later fetch of the same address hits, issues no request and yields the same words.
- R4: Cache words are written into slots 0,1,2,… in arrival order and wrap after the last slot. Writing a slot that belongs to a stored packet removes that packet's tag, so a later fetch of it misses. Other packets still hit.
- R5: Tags are reused in allocation order. With all 16 tags in use, a new miss discards the oldest tag, so a later fetch of that address requests memory again.
- R6: A fetch accepted while a packet runs takes effect only after the running packet's end-of-packet word is accepted.
- R7: At most one fetch is pending. fetch_stall is high from the cycle after a fetch is accepted until its packet starts. A fetch presented while fetch_stall is high is ignored and issues no request.
- R8: Buffer words are issued once each, in write order, with instr_src high. The buffer holds 16 words. A write while it is full is dropped.
- R9: When the buffer holds a word and a cache packet is ready at a packet boundary, the buffer packet runs first.
- R10: A started packet issues all its words up to its end-of-packet word before any word of another packet appears.
- R11: A fetch with fetch_persist high repeats its packet. A next_cmd pulse during a run stops the repetition once that run's end-of-packet word is accepted.
- R12: A new fetch accepted while a persistent packet runs ends the repetition. The newly fetched packet follows the current run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch command strobe |
| fetch_addr | input | 16 | Packet start address |
| fetch_persist | input | 1 | Fetch repeats its packet |
| next_cmd | input | 1 | Stop repeating the persistent packet |
| fetch_stall | output | 1 | A fetch is pending; further fetches are ignored |
| mem_req_valid | output | 1 | One-cycle packet request to memory |
| mem_req_addr | output | 16 | Address of the requested packet |
| mem_rsp_valid | input | 1 | Returned instruction word strobe |
| mem_rsp_data | input | 32 | Returned instruction word |
| buf_wr_valid | input | 1 | Instruction buffer write strobe |
| buf_wr_data | input | 32 | Word written into the instruction buffer |
| stall_in | input | 1 | Downstream stall |
| instr_valid | output | 1 | Instruction available to decode |
| instr_data | output | 32 | Instruction word |
| instr_src | output | 1 | 1 = word from buffer, 0 = from cache |

## Verification
A wrong tag or slot pointer shows up as a wrong instruction word, or as a memory request that appears or is missing, within the next fetch of the affected packet. A selection fault shows up at the very next packet boundary as words in the wrong order or from the wrong source. A persistence fault shows up one run late as one extra or one missing repetition. The scoreboard therefore compares every issued word in order against packets computed from their addresses, and it counts memory requests around hit and miss cases.

// File: rtl/pfe_pkg.sv
package pfe_pkg;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_BUF,
        RS_CACHE
    } run_state_e;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_REQ,
        FS_WAIT
    } fill_state_e;

endpackage

// File: rtl/pfe_word_store.sv
module pfe_word_store #(
    parameter int W     = 32,
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [W-1:0]             wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [W-1:0]             rd_data
);
    logic [W-1:0] words_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            words_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = words_q[rd_addr];
endmodule

// File: rtl/pfe_inst_fifo.sv
module pfe_inst_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slot_q [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          full, push, pop;

    assign full  = (cnt_q == CW'(DEPTH));
    assign empty = (cnt_q == '0);
    assign push  = wr_en && !full;
    assign pop   = rd_en && !empty;

    always_ff @(posedge clk) begin
        if (push) begin
            slot_q[wp_q] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wp_q <= wp_q + 1'b1;
            if (pop)  rp_q <= rp_q + 1'b1;
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign rd_data = slot_q[rp_q];

    // R8: a write into a full buffer leaves its occupancy unchanged
    assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/pfe_tag_table.sv
module pfe_tag_table #(
    parameter int AW        = 16,
    parameter int TAG_COUNT = 16,
    parameter int SW        = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [AW-1:0]                lookup_addr,
    output logic                         hit,
    output logic [SW-1:0]                hit_slot,
    input  logic                         alloc_en,
    output logic [$clog2(TAG_COUNT)-1:0] alloc_idx,
    input  logic                         commit_en,
    input  logic [$clog2(TAG_COUNT)-1:0] commit_idx,
    input  logic [AW-1:0]                commit_addr,
    input  logic [SW-1:0]                commit_start,
    input  logic [SW-1:0]                commit_end,
    input  logic                         wr_en,
    input  logic [SW-1:0]                wr_slot,
    input  logic [$clog2(TAG_COUNT)-1:0] wr_keep
);
    localparam int TW = $clog2(TAG_COUNT);

    logic [TAG_COUNT-1:0] valid_q;
    logic [AW-1:0]        addr_q  [TAG_COUNT];
    logic [SW-1:0]        start_q [TAG_COUNT];
    logic [SW-1:0]        end_q   [TAG_COUNT];
    logic [TW-1:0]        ptr_q;
    logic [TAG_COUNT-1:0] match, clobber;

    function automatic logic span_has(input logic [SW-1:0] s, input logic [SW-1:0] e,
                                      input logic [SW-1:0] x);
        if (s <= e) return (x >= s) && (x <= e);
        return (x >= s) || (x <= e);
    endfunction

    for (genvar g = 0; g < TAG_COUNT; g++) begin : g_entry
        assign match[g]   = valid_q[g] && (addr_q[g] == lookup_addr);
        assign clobber[g] = wr_en && (TW'(g) != wr_keep) && valid_q[g]
                            && span_has(start_q[g], end_q[g], wr_slot);
    end

    always_comb begin
        hit      = |match;
        hit_slot = '0;
        for (int i = 0; i < TAG_COUNT; i++) begin
            if (match[i]) hit_slot = hit_slot | start_q[i];
        end
    end

    assign alloc_idx = ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ptr_q   <= '0;
        end else begin
            for (int i = 0; i < TAG_COUNT; i++) begin
                if (clobber[i]) valid_q[i] <= 1'b0;
            end
            if (alloc_en) begin
                valid_q[ptr_q] <= 1'b0;
                ptr_q          <= ptr_q + 1'b1;
            end
            if (commit_en) valid_q[commit_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (commit_en) begin
            addr_q[commit_idx]  <= commit_addr;
            start_q[commit_idx] <= commit_start;
            end_q[commit_idx]   <= commit_end;
        end
    end

    // R3: misses alone allocate, so an address never sits in two live tags
    assert_unique_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/pkt_front_end.sv
module pkt_front_end
    import pfe_pkg::*;
#(
    parameter int IW          = 32,
    parameter int AW          = 16,
    parameter int CACHE_WORDS = 64,
    parameter int TAG_COUNT   = 16,
    parameter int BUF_WORDS   = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_addr,
    input  logic          fetch_persist,
    input  logic          next_cmd,
    output logic          fetch_stall,
    output logic          mem_req_valid,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [IW-1:0] mem_rsp_data,
    input  logic          buf_wr_valid,
    input  logic [IW-1:0] buf_wr_data,
    input  logic          stall_in,
    output logic          instr_valid,
    output logic [IW-1:0] instr_data,
    output logic          instr_src
);
    localparam int SW = $clog2(CACHE_WORDS);
    localparam int TW = $clog2(TAG_COUNT);

    run_state_e  rs_q, rs_d;
    fill_state_e fs_q, fs_d;

    logic          pend_valid_q, pend_ready_q, pend_persist_q;
    logic [AW-1:0] pend_addr_q;
    logic [SW-1:0] pend_slot_q;
    logic          persist_q;
    logic [SW-1:0] run_start_q, rd_ptr_q, fill_ptr_q, fill_start_q;
    logic [TW-1:0] fill_tag_q;

    logic          hit;
    logic [SW-1:0] hit_slot;
    logic [TW-1:0] alloc_idx;
    logic          buf_empty;
    logic [IW-1:0] buf_head, store_word;

    logic accept, miss_alloc, fill_wr, fill_last, fire, word_eop;
    logic pick_buf, pick_pend, pick_rep;

    assign accept     = fetch_valid && !pend_valid_q;
    assign miss_alloc = accept && !hit;
    assign fill_wr    = (fs_q == FS_WAIT) && mem_rsp_valid;
    assign fill_last  = fill_wr && mem_rsp_data[IW-1];
    assign fire       = instr_valid && !stall_in;
    assign word_eop   = instr_data[IW-1];

    assign pick_buf  = (rs_q == RS_IDLE) && !buf_empty;
    assign pick_pend = (rs_q == RS_IDLE) && buf_empty && pend_ready_q;
    assign pick_rep  = (rs_q == RS_IDLE) && buf_empty && !pend_ready_q
                       && persist_q && !next_cmd && !accept;

    pfe_tag_table #(.AW(AW), .TAG_COUNT(TAG_COUNT), .SW(SW)) u_tags (
        .clk          (clk),
        .rst_n        (rst_n),
        .lookup_addr  (fetch_addr),
        .hit          (hit),
        .hit_slot     (hit_slot),
        .alloc_en     (miss_alloc),
        .alloc_idx    (alloc_idx),
        .commit_en    (fill_last),
        .commit_idx   (fill_tag_q),
        .commit_addr  (pend_addr_q),
        .commit_start (fill_start_q),
        .commit_end   (fill_ptr_q),
        .wr_en        (fill_wr),
        .wr_slot      (fill_ptr_q),
        .wr_keep      (fill_tag_q)
    );

    pfe_word_store #(.W(IW), .DEPTH(CACHE_WORDS)) u_store (
        .clk     (clk),
        .wr_en   (fill_wr),
        .wr_addr (fill_ptr_q),
        .wr_data (mem_rsp_data),
        .rd_addr (rd_ptr_q),
        .rd_data (store_word)
    );

    pfe_inst_fifo #(.W(IW), .DEPTH(BUF_WORDS)) u_ibuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_wr_valid),
        .wr_data (buf_wr_data),
        .rd_en   ((rs_q == RS_BUF) && fire),
        .rd_data (buf_head),
        .empty   (buf_empty)
    );

    // next-state logic for both machines
    always_comb begin
        rs_d = rs_q;
        unique case (rs_q)
            RS_IDLE:  if (pick_buf) rs_d = RS_BUF;
                      else if (pick_pend || pick_rep) rs_d = RS_CACHE;
            RS_BUF:   if (fire && word_eop) rs_d = RS_IDLE;
            RS_CACHE: if (fire && word_eop) rs_d = RS_IDLE;
            default:  rs_d = RS_IDLE;
        endcase
        fs_d = fs_q;
        unique case (fs_q)
            FS_IDLE: if (miss_alloc) fs_d = FS_REQ;
            FS_REQ:  fs_d = FS_WAIT;
            FS_WAIT: if (fill_last) fs_d = FS_IDLE;
            default: fs_d = FS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_q <= RS_IDLE;
            fs_q <= FS_IDLE;
        end else begin
            rs_q <= rs_d;
            fs_q <= fs_d;
        end
    end

    // pending slot, pointers and persistence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid_q   <= 1'b0;
            pend_ready_q   <= 1'b0;
            pend_persist_q <= 1'b0;
            pend_addr_q    <= '0;
            pend_slot_q    <= '0;
            persist_q      <= 1'b0;
            run_start_q    <= '0;
            rd_ptr_q       <= '0;
            fill_ptr_q     <= '0;
            fill_start_q   <= '0;
            fill_tag_q     <= '0;
        end else begin
            if (next_cmd || accept) persist_q <= 1'b0;
            if (accept) begin
                pend_valid_q   <= 1'b1;
                pend_addr_q    <= fetch_addr;
                pend_persist_q <= fetch_persist;
                pend_ready_q   <= hit;
                pend_slot_q    <= hit_slot;
                if (!hit) begin
                    fill_start_q <= fill_ptr_q;
                    fill_tag_q   <= alloc_idx;
                end
            end
            if (fill_wr) begin
                fill_ptr_q <= fill_ptr_q + 1'b1;
                if (fill_last) begin
                    pend_ready_q <= 1'b1;
                    pend_slot_q  <= fill_start_q;
                end
            end
            if (pick_pend) begin
                pend_valid_q <= 1'b0;
                pend_ready_q <= 1'b0;
                rd_ptr_q     <= pend_slot_q;
                run_start_q  <= pend_slot_q;
                persist_q    <= pend_persist_q;
            end else if (pick_rep) begin
                rd_ptr_q <= run_start_q;
            end else if ((rs_q == RS_CACHE) && fire) begin
                rd_ptr_q <= rd_ptr_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        mem_req_valid = (fs_q == FS_REQ);
        mem_req_addr  = pend_addr_q;
        fetch_stall   = pend_valid_q;
        instr_src     = (rs_q == RS_BUF);
        instr_valid   = (rs_q == RS_CACHE) || ((rs_q == RS_BUF) && !buf_empty);
        instr_data    = (rs_q == RS_BUF) ? buf_head : store_word;
    end

    // R3: each miss produces a single-cycle request
    assert_one_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R7: memory is only asked for a packet that sits in the pending slot
    assert_req_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> fetch_stall);

    // R2: a stalled instruction is held
    assert_hold_stalled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && stall_in) |=> (instr_valid && $stable(instr_data)));

    // R10: no source switch inside a packet
    assert_no_interleave_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !stall_in && !instr_data[IW-1]) |=> (instr_src == $past(instr_src)));
endmodule

// File: tb/sim_pkt_front_end.sv
module sim_pkt_front_end;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fetch_valid, fetch_persist, next_cmd;
    logic [15:0] fetch_addr;
    logic        fetch_stall, mem_req_valid;
    logic [15:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        buf_wr_valid;
    logic [31:0] buf_wr_data;
    logic        stall_in;
    logic        instr_valid, instr_src;
    logic [31:0] instr_data;

    int checks = 0;
    int errors = 0;
    int req_count = 0;
    int cycles = 0;

    logic [31:0] exp_d[$];
    logic        exp_s[$];
    string       exp_r[$];
    string       last_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_front_end u0 (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_persist(fetch_persist),
        .next_cmd(next_cmd), .fetch_stall(fetch_stall),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .buf_wr_valid(buf_wr_valid), .buf_wr_data(buf_wr_data),
        .stall_in(stall_in),
        .instr_valid(instr_valid), .instr_data(instr_data), .instr_src(instr_src)
    );

    function automatic int plen(input logic [15:0] a);
        return int'(a[3:0]) + 1;
    endfunction

    function automatic logic [31:0] pword(input logic [15:0] a, input int k);
        return {(k == plen(a) - 1), 15'd0, a[7:0], 8'(k)};
    endfunction

    function automatic logic [31:0] bword(input logic [7:0] id, input int k, input logic eop);
        return {eop, 15'd1, id, 8'(k)};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic expect_pkt(input logic [15:0] a, input string req);
        for (int k = 0; k < plen(a); k++) begin
            exp_d.push_back(pword(a, k));
            exp_s.push_back(1'b0);
            exp_r.push_back(req);
        end
    endtask

    task automatic expect_buf(input logic [7:0] id, input int n, input string req);
        for (int k = 0; k < n; k++) begin
            exp_d.push_back(bword(id, k, k == n - 1));
            exp_s.push_back(1'b1);
            exp_r.push_back(req);
        end
    endtask

    task automatic do_fetch(input logic [15:0] a, input logic p);
        @(posedge clk); #1;
        while (fetch_stall) begin
            @(posedge clk); #1;
        end
        fetch_valid = 1'b1; fetch_addr = a; fetch_persist = p;
        @(posedge clk); #1;
        fetch_valid = 1'b0; fetch_persist = 1'b0;
    endtask

    task automatic write_buf(input logic [7:0] id, input int n, input int stored);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            buf_wr_valid = 1'b1;
            buf_wr_data  = bword(id, k, k == stored - 1);
        end
        @(posedge clk); #1;
        buf_wr_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_d.size() != 0) @(posedge clk);
        repeat (8) @(posedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && instr_valid && !stall_in) begin
            if (exp_d.size() == 0) begin
                checks++; errors++;
                $display("FAIL %s unexpected word actual=%h expected=none", last_req, instr_data);
            end else begin
                logic [31:0] d;
                logic        s;
                string       r;
                d = exp_d.pop_front(); s = exp_s.pop_front(); r = exp_r.pop_front();
                last_req = r;
                checks++;
                if (instr_data !== d || instr_src !== s) begin
                    errors++;
                    $display("FAIL %s word actual=%h/%0b expected=%h/%0b", r, instr_data, instr_src, d, s);
                end
            end
        end
    end

    // memory model: 2 cycles latency, one word per cycle
    always @(negedge clk) begin
        if (rst_n && mem_req_valid) begin
            logic [15:0] a;
            a = mem_req_addr;
            req_count++;
            repeat (2) @(posedge clk);
            for (int k = 0; k < plen(a); k++) begin
                #1 mem_rsp_valid = 1'b1; mem_rsp_data = pword(a, k);
                @(posedge clk);
            end
            #1 mem_rsp_valid = 1'b0;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=%0d expected=done", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int r0;
        rst_n = 1'b0; fetch_valid = 1'b0; fetch_addr = '0; fetch_persist = 1'b0;
        next_cmd = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        buf_wr_valid = 1'b0; buf_wr_data = '0; stall_in = 1'b0;
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(instr_valid == 1'b0, "R1", "instr_valid", instr_valid, 0);
        check(mem_req_valid == 1'b0, "R1", "mem_req_valid", mem_req_valid, 0);
        check(fetch_stall == 1'b0, "R1", "fetch_stall", fetch_stall, 0);

        // R3 miss then hit
        expect_pkt(16'h0012, "R3");
        do_fetch(16'h0012, 1'b0);
        drain();
        check(req_count == 1, "R3", "requests after miss", req_count, 1);
        expect_pkt(16'h0012, "R3");
        do_fetch(16'h0012, 1'b0);
        drain();
        check(req_count == 1, "R3", "requests after hit", req_count, 1);

        // R2 stall hold, R6 deferral, R7 single pending, R9 priority, R10 no interleave
        stall_in = 1'b1;
        expect_pkt(16'h0023, "R10");
        expect_buf(8'h01, 3, "R9");
        expect_pkt(16'h0012, "R6");
        do_fetch(16'h0023, 1'b0);
        repeat (20) @(posedge clk);
        @(negedge clk);
        check(instr_valid == 1'b1, "R2", "valid under stall", instr_valid, 1);
        check(instr_data == pword(16'h0023, 0), "R2", "held word", instr_data, pword(16'h0023, 0));
        write_buf(8'h01, 3, 3);
        do_fetch(16'h0012, 1'b0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(fetch_stall == 1'b1, "R7", "fetch_stall while pending", fetch_stall, 1);
        @(posedge clk); #1;
        fetch_valid = 1'b1; fetch_addr = 16'h0034;
        @(posedge clk); #1;
        fetch_valid = 1'b0;
        repeat (6) @(posedge clk);
        @(negedge clk);
        check(instr_data == pword(16'h0023, 0), "R2", "still held", instr_data, pword(16'h0023, 0));
        @(posedge clk); #1;
        stall_in = 1'b0;
        drain();
        check(req_count == 2, "R7", "ignored fetch made no request", req_count, 2);

        // R11 persistent repeat stopped by next_cmd
        for (int i = 0; i < 3; i++) expect_pkt(16'h0043, "R11");
        do_fetch(16'h0043, 1'b1);
        @(negedge clk);
        while (exp_d.size() >= 4) @(negedge clk);
        @(posedge clk); #1 next_cmd = 1'b1;
        @(posedge clk); #1 next_cmd = 1'b0;
        drain();
        check(exp_d.size() == 0, "R11", "repetitions consumed", exp_d.size(), 0);

        // R12 persistent repeat ended by a new fetch
        for (int i = 0; i < 2; i++) expect_pkt(16'h0053, "R12");
        expect_pkt(16'h0012, "R12");
        do_fetch(16'h0053, 1'b1);
        @(negedge clk);
        while (exp_d.size() >= 7) @(negedge clk);
        do_fetch(16'h0012, 1'b0);
        drain();
        check(req_count == 4, "R12", "requests", req_count, 4);

        // R5 tag FIFO eviction
        for (int i = 0; i < 16; i++) begin
            logic [15:0] a;
            a = 16'h0600 + 16'(i * 16);
            expect_pkt(a, "R5");
            do_fetch(a, 1'b0);
        end
        drain();
        r0 = req_count;
        expect_pkt(16'h0012, "R5");
        do_fetch(16'h0012, 1'b0);
        drain();
        check(req_count == r0 + 1, "R5", "oldest tag evicted", req_count, r0 + 1);
        expect_pkt(16'h06F0, "R5");
        do_fetch(16'h06F0, 1'b0);
        drain();
        check(req_count == r0 + 1, "R5", "newest tag kept", req_count, r0 + 1);

        // R8 buffer order, capacity and dropped write
        stall_in = 1'b1;
        expect_buf(8'h02, 16, "R8");
        write_buf(8'h02, 17, 16);
        @(posedge clk); #1;
        stall_in = 1'b0;
        drain();
        check(exp_d.size() == 0, "R8", "buffer drained", exp_d.size(), 0);

        // R4 word slot wrap eviction, after a fresh reset
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (2) @(posedge clk); #1 rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            logic [15:0] a;
            a = 16'h000F + 16'(i * 16);
            expect_pkt(a, "R4");
            do_fetch(a, 1'b0);
        end
        drain();
        r0 = req_count;
        expect_pkt(16'h001F, "R4");
        do_fetch(16'h001F, 1'b0);
        drain();
        check(req_count == r0, "R4", "untouched packet hits", req_count, r0);
        expect_pkt(16'h000F, "R4");
        do_fetch(16'h000F, 1'b0);
        drain();
        check(req_count == r0 + 1, "R4", "overwritten packet misses", req_count, r0 + 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule